// File: doc/BRIEF.md
# Monochrome Glyph Expansion Engine

This block expands a one-bit-per-pixel bitmap into a stream of coloured pixel writes for a frame buffer. Software first loads a packed start position, a glyph width, a per-row position increment, foreground and background colours, a raster operation and an opaque/transparent mode through a small register-write port. It then pushes row words, one 32-bit word per row, through a valid/ready handshake.

For each accepted row word the engine walks the leftmost `width` bits, starting at bit 31. It uses one cycle per bit position and emits a pixel request (x, y, colour, read-modify-write flag) whenever that pixel is to be written. Each accepted row advances the stored position by the increment, so a glyph taller than one row needs no further set-up. The row settings are captured when a row is accepted. Rows can follow each other with no idle cycle between them.

Top module: `glyph_expander`

## Requirements
- R1: After reset, `row_ready` is 1 and `px_valid` is 0. The registers hold position 0, increment 0, width 32, both colours 0, the write-new operation and opaque mode.
- R2: Select 1 sets the width from `cfg_wdata[31:0]`. Each row emits at most that many pixels, taken from bit 31 downward, and lower bits are ignored. A value of 0 or above 32 means 32.
- R3: A set bit takes the foreground colour and a clear bit takes the background colour. Colours are 24-bit, with red in [7:0], green in [15:8] and blue in [23:16]. Select 3 writes the foreground from `cfg_wdata[23:0]` and select 4 writes the background from `cfg_wdata[23:0]`. Select 5 writes both: foreground from `cfg_wdata[55:32]` and background from `cfg_wdata[23:0]`.
- R4: Select 7, bit 0, sets the mode: 1 is transparent, 0 is opaque. In transparent mode clear bits produce no request. In opaque mode they are written.
- R5: Select 6 sets the raster operation from `cfg_wdata[7:0]`. Code 0x85 keeps the old pixel, so the row produces no requests. Code 0x86 sets `px_rmw` to 1 (new XOR old). Any other code, 0x83 included, writes the new colour with `px_rmw` at 0.
- R6: Select 0 writes the position: y in bits 31:16 and x in bits 15:0. The pixel for bit 31-i is at x0+i (modulo 2^16), and y stays at y0 for the whole row.
- R7: Each accepted row adds the select-2 increment to the 32-bit position, with wraparound. If a position write and a row acceptance happen in the same cycle, the row draws at the old position and the written value replaces the advance.
- R8: With `px_ready` held at 1, one bit position is consumed per cycle. `row_ready` is 1 when the engine is idle and in the cycle of a row's last bit, so back-to-back rows of width W are accepted exactly W cycles apart.
- R9: While `px_valid` is 1 and `px_ready` is 0, the request stays unchanged into the next cycle.
- R10: Register writes made while a row is being drawn do not affect that row. They take effect from the next accepted row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 position, 1 width, 2 increment, 3 fg, 4 bg, 5 fg+bg, 6 raster op, 7 mode) |
| cfg_wdata | input | 64 | Register write data |
| row_valid | input | 1 | Row word offered |
| row_ready | output | 1 | Engine can take a row word this cycle |
| row_data | input | 32 | Row bitmap, leftmost pixel in bit 31 |
| px_valid | output | 1 | Pixel request valid |
| px_ready | input | 1 | Pixel sink accepts the request |
| px_x | output | 16 | Pixel x coordinate |
| px_y | output | 16 | Pixel y coordinate |
| px_color | output | 24 | Pixel colour |
| px_rmw | output | 1 | Combine the colour with the stored pixel by XOR |

## Verification
The assertions check on every cycle the properties that can be seen from the registers:
- the request holds under back-pressure;
- the idle state leaves `row_ready` high with no request;
- the column index stays below the captured width;
- y stays constant within a row;
- the position register either advances by the increment or takes a same-cycle write.

The bench scenarios show what needs a whole row to judge: which bits become pixels, their colours, their order and x values, the handling of transparent mode and of the raster codes, widths of 0 and above 32, coordinate wraparound, the spacing between back-to-back rows, and that settings written mid-row leave that row untouched.

// File: rtl/glyph_pkg.sv
// Shared constants and types for the glyph expansion engine.
// Assumes a 32-bit row word and 24-bit colours.
package glyph_pkg;
    localparam int ROW_W   = 32;
    localparam int COLOR_W = 24;
    localparam int CNT_W   = $clog2(ROW_W + 1);

    // Register select codes on cfg_sel
    typedef enum logic [2:0] {
        SEL_POS   = 3'd0,
        SEL_WIDTH = 3'd1,
        SEL_STEP  = 3'd2,
        SEL_FG    = 3'd3,
        SEL_BG    = 3'd4,
        SEL_FGBG  = 3'd5,
        SEL_ROP   = 3'd6,
        SEL_MODE  = 3'd7
    } cfg_sel_e;

    localparam logic [7:0] ROP_KEEP_CODE = 8'h85;
    localparam logic [7:0] ROP_XOR_CODE  = 8'h86;

    // Decoded raster operation
    typedef enum logic [1:0] {
        RM_NEW  = 2'd0,
        RM_KEEP = 2'd1,
        RM_XOR  = 2'd2
    } rop_mode_e;

    // Per-row drawing settings, captured when a row is accepted
    typedef struct packed {
        logic [COLOR_W-1:0] fg;
        logic [COLOR_W-1:0] bg;
        rop_mode_e          rop;
        logic               transparent;
        logic [CNT_W-1:0]   width;
    } row_ctx_t;
endpackage

// File: rtl/glyph_cfg_regs.sv
// Configuration register bank of the glyph engine.
// Holds the packed position, increment, width, colours, raster op and mode.
// The width and raster op are decoded on write. The position advances by the
// increment on every accepted row, and a same-cycle position write wins.
module glyph_cfg_regs
    import glyph_pkg::*;
#(
    parameter int X_W = 16,
    parameter int Y_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_sel,
    input  logic [63:0]          cfg_wdata,
    input  logic                 adv,
    output logic [X_W+Y_W-1:0]   pos_q,
    output logic [X_W+Y_W-1:0]   step_q,
    output row_ctx_t             ctx
);
    localparam int POS_W = X_W + Y_W;

    logic [31:0]      wreq;
    logic [CNT_W-1:0] width_dec;
    rop_mode_e        rop_dec;
    logic             unused_hi;

    assign wreq      = cfg_wdata[31:0];
    assign unused_hi = ^cfg_wdata[63:56];

    // Clamp the requested width into 1..ROW_W
    always_comb begin
        if (wreq == 32'd0 || wreq > 32'(ROW_W))
            width_dec = CNT_W'(ROW_W);
        else
            width_dec = wreq[CNT_W-1:0];
    end

    // Decode the raster operation code
    always_comb begin
        case (cfg_wdata[7:0])
            ROP_KEEP_CODE: rop_dec = RM_KEEP;
            ROP_XOR_CODE:  rop_dec = RM_XOR;
            default:       rop_dec = RM_NEW;
        endcase
    end

    // Position register: a software write beats the per-row advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (cfg_we && cfg_sel_e'(cfg_sel) == SEL_POS)
            pos_q <= cfg_wdata[POS_W-1:0];
        else if (adv)
            pos_q <= pos_q + step_q;
    end

    // Remaining configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q          <= '0;
            ctx.fg          <= '0;
            ctx.bg          <= '0;
            ctx.rop         <= RM_NEW;
            ctx.transparent <= 1'b0;
            ctx.width       <= CNT_W'(ROW_W);
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_WIDTH: ctx.width <= width_dec;
                SEL_STEP:  step_q    <= cfg_wdata[POS_W-1:0];
                SEL_FG:    ctx.fg    <= cfg_wdata[COLOR_W-1:0];
                SEL_BG:    ctx.bg    <= cfg_wdata[COLOR_W-1:0];
                SEL_FGBG: begin
                    ctx.fg <= cfg_wdata[32 +: COLOR_W];
                    ctx.bg <= cfg_wdata[0 +: COLOR_W];
                end
                SEL_ROP:   ctx.rop         <= rop_dec;
                SEL_MODE:  ctx.transparent <= cfg_wdata[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/glyph_row_walker.sv
// Row walker: captures a row word with its settings and start position, then
// steps one bit per cycle whenever the current pixel is absent or accepted.
// It is ready again in the cycle that consumes the last bit, so rows can
// follow each other without a gap.
module glyph_row_walker
    import glyph_pkg::*;
#(
    parameter int X_W = 16,
    parameter int Y_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 row_valid,
    input  logic [ROW_W-1:0]     row_data,
    output logic                 row_ready,
    output logic                 accept,
    input  logic [X_W+Y_W-1:0]   pos_q,
    input  row_ctx_t             ctx_in,
    input  logic                 emit,
    input  logic                 px_ready,
    output logic                 busy,
    output logic                 bit_now,
    output logic [CNT_W-1:0]     col,
    output logic [X_W-1:0]       x0,
    output logic [Y_W-1:0]       y0,
    output row_ctx_t             ctx_q
);
    localparam int POS_W = X_W + Y_W;

    logic [ROW_W-1:0] bits_q;
    logic             advance;
    logic             last;

    // Step when the current pixel needs no write or the sink takes it
    assign advance   = busy && (!emit || px_ready);
    assign last      = (col == ctx_q.width - 1'b1);
    assign row_ready = !busy || (advance && last);
    assign accept    = row_valid && row_ready;
    assign bit_now   = bits_q[ROW_W-1];

    // Row state: load on accept, shift and count on advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            bits_q <= '0;
            col    <= '0;
            x0     <= '0;
            y0     <= '0;
            ctx_q  <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            bits_q <= row_data;
            col    <= '0;
            x0     <= pos_q[X_W-1:0];
            y0     <= pos_q[POS_W-1:X_W];
            ctx_q  <= ctx_in;
        end else if (advance) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                bits_q <= bits_q << 1;
                col    <= col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/glyph_pixel_emit.sv
// Pixel request former: chooses the colour from the current bit, applies the
// transparent skip and the raster op, and forms x from the start plus the column.
// Purely combinational on the walker state.
module glyph_pixel_emit
    import glyph_pkg::*;
#(
    parameter int X_W = 16,
    parameter int Y_W = 16
) (
    input  logic               busy,
    input  logic               bit_now,
    input  logic [CNT_W-1:0]   col,
    input  logic [X_W-1:0]     x0,
    input  logic [Y_W-1:0]     y0,
    input  logic [COLOR_W-1:0] fg,
    input  logic [COLOR_W-1:0] bg,
    input  rop_mode_e          rop,
    input  logic               transparent,
    output logic               px_valid,
    output logic [X_W-1:0]     px_x,
    output logic [Y_W-1:0]     px_y,
    output logic [COLOR_W-1:0] px_color,
    output logic               px_rmw
);
    // Request formation for the current bit position
    always_comb begin
        px_valid = busy && (rop != RM_KEEP) && (bit_now || !transparent);
        px_x     = x0 + X_W'(col);
        px_y     = y0;
        px_color = bit_now ? fg : bg;
        px_rmw   = (rop == RM_XOR);
    end
endmodule

// File: rtl/glyph_expander.sv
// Top of the monochrome glyph expansion engine.
// It ties the register bank, the row walker and the request former together.
// Assumes the pixel sink handles XOR requests as read-modify-write.
module glyph_expander
    import glyph_pkg::*;
#(
    parameter int X_W = 16,
    parameter int Y_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [63:0]        cfg_wdata,
    input  logic               row_valid,
    output logic               row_ready,
    input  logic [31:0]        row_data,
    output logic               px_valid,
    input  logic               px_ready,
    output logic [X_W-1:0]     px_x,
    output logic [Y_W-1:0]     px_y,
    output logic [23:0]        px_color,
    output logic               px_rmw
);
    localparam int POS_W = X_W + Y_W;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] step_q;
    row_ctx_t         cfg_ctx;
    row_ctx_t         row_ctx;
    logic             row_accept;
    logic             walk_busy;
    logic             walk_bit;
    logic [CNT_W-1:0] walk_col;
    logic [X_W-1:0]   walk_x0;
    logic [Y_W-1:0]   walk_y0;

    glyph_cfg_regs #(.X_W(X_W), .Y_W(Y_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .adv(row_accept), .pos_q(pos_q),
        .step_q(step_q), .ctx(cfg_ctx)
    );

    glyph_row_walker #(.X_W(X_W), .Y_W(Y_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_data(row_data),
        .row_ready(row_ready), .accept(row_accept), .pos_q(pos_q),
        .ctx_in(cfg_ctx), .emit(px_valid), .px_ready(px_ready),
        .busy(walk_busy), .bit_now(walk_bit), .col(walk_col),
        .x0(walk_x0), .y0(walk_y0), .ctx_q(row_ctx)
    );

    glyph_pixel_emit #(.X_W(X_W), .Y_W(Y_W)) u_emit (
        .busy(walk_busy), .bit_now(walk_bit), .col(walk_col),
        .x0(walk_x0), .y0(walk_y0), .fg(row_ctx.fg), .bg(row_ctx.bg),
        .rop(row_ctx.rop), .transparent(row_ctx.transparent),
        .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
        .px_color(px_color), .px_rmw(px_rmw)
    );
endmodule

// File: rtl/glyph_expander_chk.sv
// Property checker for the glyph engine, bound to the top module.
module glyph_expander_chk #(
    parameter int X_W   = 16,
    parameter int Y_W   = 16,
    parameter int CNT_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [2:0]         cfg_sel,
    input logic [63:0]        cfg_wdata,
    input logic               row_ready,
    input logic               row_accept,
    input logic               px_valid,
    input logic               px_ready,
    input logic [X_W-1:0]     px_x,
    input logic [Y_W-1:0]     px_y,
    input logic [23:0]        px_color,
    input logic               px_rmw,
    input logic               busy,
    input logic [CNT_W-1:0]   col,
    input logic [CNT_W-1:0]   width_q,
    input logic [X_W+Y_W-1:0] pos_q,
    input logic [X_W+Y_W-1:0] step_q
);
    localparam int POS_W = X_W + Y_W;

    logic pos_wr;
    assign pos_wr = cfg_we && (cfg_sel == 3'd0);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (px_valid && !px_ready) |=> (px_valid && $stable(px_x) && $stable(px_y)
                                     && $stable(px_color) && $stable(px_rmw)));

    // R7
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_accept && !pos_wr) |=> (pos_q == POS_W'($past(pos_q) + $past(step_q))));

    // R7
    pos_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_wr |=> (pos_q == $past(cfg_wdata[POS_W-1:0])));

    // R8
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (row_ready && !px_valid));

    // R2
    col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (col < width_q));

    // R6
    row_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !row_accept) |=> $stable(px_y));
endmodule

bind glyph_expander glyph_expander_chk #(.X_W(X_W), .Y_W(Y_W), .CNT_W(glyph_pkg::CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .row_ready(row_ready), .row_accept(row_accept),
    .px_valid(px_valid), .px_ready(px_ready), .px_x(px_x), .px_y(px_y),
    .px_color(px_color), .px_rmw(px_rmw), .busy(walk_busy), .col(walk_col),
    .width_q(row_ctx.width), .pos_q(pos_q), .step_q(step_q)
);

// File: tb/glyph_expander_test.sv
module glyph_expander_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [63:0] cfg_wdata;
    logic        row_valid;
    logic        row_ready;
    logic [31:0] row_data;
    logic        px_valid;
    logic        px_ready;
    logic [15:0] px_x;
    logic [15:0] px_y;
    logic [23:0] px_color;
    logic        px_rmw;

    always #2 clk = ~clk;

    glyph_expander uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .row_valid(row_valid), .row_ready(row_ready),
        .row_data(row_data), .px_valid(px_valid), .px_ready(px_ready),
        .px_x(px_x), .px_y(px_y), .px_color(px_color), .px_rmw(px_rmw)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int ncap  = 0;
    int n_hold = 0;
    bit finished = 0;

    logic [15:0] cap_x [0:255];
    logic [15:0] cap_y [0:255];
    logic [23:0] cap_c [0:255];
    logic        cap_r [0:255];

    logic        hold_armed = 1'b0;
    logic [56:0] hold_val;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: record accepted requests and check holds under back-pressure (R9)
    always @(negedge clk) begin
        if (hold_armed) begin
            n_cmp++;
            n_hold++;
            if (px_valid !== 1'b1 || {px_x, px_y, px_color, px_rmw} !== hold_val) begin
                n_bad++;
                $display("FAIL R9 stalled request changed: got %h expected %h",
                         {px_x, px_y, px_color, px_rmw}, hold_val);
            end
        end
        hold_armed = rst_n && px_valid && !px_ready;
        hold_val   = {px_x, px_y, px_color, px_rmw};
        if (rst_n && px_valid && px_ready && ncap < 256) begin
            cap_x[ncap] = px_x;
            cap_y[ncap] = px_y;
            cap_c[ncap] = px_color;
            cap_r[ncap] = px_rmw;
            ncap++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Entry and exit one time unit after a rising edge
    task automatic cfg_write(input logic [2:0] sel, input logic [63:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic send_row(input logic [31:0] d, output int t);
        bit ok;
        row_data = d; row_valid = 1'b1;
        do begin
            @(negedge clk);
            ok = row_ready;
            t  = cyc;
            @(posedge clk); #1;
        end while (!ok);
        row_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int eff_w(input logic [31:0] w);
        return (w == 0 || w > 32) ? 32 : int'(w);
    endfunction

    // Expected requests of two rows (d0, d1), compared with the capture
    task automatic verify_rows(input string req, input logic [31:0] pos, input logic [31:0] step,
                               input logic [31:0] w, input logic [23:0] fg, input logic [23:0] bg,
                               input logic [7:0] rop, input logic transp,
                               input logic [31:0] d0, input logic [31:0] d1);
        int k = 0;
        int we = eff_w(w);
        for (int r = 0; r < 2; r++) begin
            logic [31:0] p = (r == 0) ? pos : pos + step;
            logic [31:0] d = (r == 0) ? d0 : d1;
            for (int i = 0; i < we; i++) begin
                logic b = d[31-i];
                if (rop != 8'h85 && (b || !transp)) begin
                    logic [56:0] e = {p[15:0] + 16'(i), p[31:16], b ? fg : bg, rop == 8'h86};
                    if (k < ncap)
                        chk(req, {7'd0, cap_x[k], cap_y[k], cap_c[k], cap_r[k]}, {7'd0, e});
                    k++;
                end
            end
        end
        chk({req, " count"}, 64'(ncap), 64'(k));
    endtask

    typedef struct packed {
        logic [31:0] pos;
        logic [31:0] step;
        logic [31:0] width;
        logic [23:0] fg;
        logic [23:0] bg;
        logic [7:0]  rop;
        logic        transp;
        logic        pair;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [0:NV-1] = '{
        // R3 R6 opaque write-new, down one line per row
        '{32'h0005_000A, 32'h0001_0000, 32'd8,  24'h112233, 24'h445566, 8'h83, 1'b0, 1'b0, 32'hA500_0000},
        // R4 transparent, R3 combined colour write
        '{32'h0010_0020, 32'h0001_0000, 32'd8,  24'hA1B2C3, 24'h0F0E0D, 8'h83, 1'b1, 1'b1, 32'hC300_0000},
        // R5 XOR flag, R7 x-only increment
        '{32'h0002_0003, 32'h0000_0008, 32'd4,  24'hABCDEF, 24'h012345, 8'h86, 1'b0, 1'b0, 32'h9000_0000},
        // R5 keep-old emits nothing
        '{32'h0004_0004, 32'h0003_0001, 32'd16, 24'h777777, 24'h333333, 8'h85, 1'b0, 1'b0, 32'hFFFF_0000},
        // R2 width 0 means 32, R4 transparent
        '{32'h0007_0000, 32'h0001_0000, 32'd0,  24'h00FF00, 24'hFF0000, 8'h83, 1'b1, 1'b0, 32'h8000_0001},
        // R2 width above 32, R5 unknown code writes new, R6 x wraps
        '{32'h0001_FFFE, 32'hFFFF_0000, 32'd40, 24'h123456, 24'h654321, 8'h00, 1'b0, 1'b1, 32'h0000_0000},
        // R7 y wraps through the 32-bit add, R5 XOR transparent
        '{32'hFFFF_0000, 32'h0001_0000, 32'd32, 24'hC0FFEE, 24'hBADBAD, 8'h86, 1'b1, 1'b1, 32'h0F0F_0F0F}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int t1, t2;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        row_valid = 1'b0; row_data = '0; px_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 row_ready after reset", 64'(row_ready), 64'd1);
        chk("R1 px_valid after reset", 64'(px_valid), 64'd0);
        @(posedge clk); #1;

        // R1 default registers: width 32, colours 0, opaque, write-new, position 0
        ncap = 0;
        send_row(32'hFFFF_0000, t1);
        send_row(32'h0000_FFFF, t2);
        idle(40);
        verify_rows("R1 defaults", 32'h0, 32'h0, 32'd32, 24'h0, 24'h0, 8'h83, 1'b0,
                    32'hFFFF_0000, 32'h0000_FFFF);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            vec_t tv = VECS[v];
            cfg_write(3'd0, {32'd0, tv.pos});
            cfg_write(3'd2, {32'd0, tv.step});
            cfg_write(3'd1, {32'd0, tv.width});
            if (tv.pair) begin
                cfg_write(3'd5, {8'd0, tv.fg, 8'd0, tv.bg});
            end else begin
                cfg_write(3'd3, {40'd0, tv.fg});
                cfg_write(3'd4, {40'd0, tv.bg});
            end
            cfg_write(3'd6, {56'd0, tv.rop});
            cfg_write(3'd7, {63'd0, tv.transp});
            ncap = 0;
            send_row(tv.data, t1);
            send_row(~tv.data, t2);
            idle(40);
            verify_rows($sformatf("R2-vector %0d", v), tv.pos, tv.step, tv.width, tv.fg, tv.bg,
                        tv.rop, tv.transp, tv.data, ~tv.data);
            // R8 back-to-back spacing equals the effective width
            chk($sformatf("R8 row spacing vector %0d", v), 64'(t2 - t1), 64'(eff_w(tv.width)));
        end

        // R10 settings written mid-row apply only to the next row
        cfg_write(3'd0, 64'h0040_0000);
        cfg_write(3'd2, 64'h0001_0000);
        cfg_write(3'd1, 64'd16);
        cfg_write(3'd3, 64'h111111);
        cfg_write(3'd4, 64'h222222);
        cfg_write(3'd6, 64'h83);
        cfg_write(3'd7, 64'h0);
        ncap = 0;
        send_row(32'hFFF0_0000, t1);
        cfg_write(3'd3, 64'h999999);
        cfg_write(3'd7, 64'h1);
        send_row(32'hFFF0_0000, t2);
        idle(40);
        chk("R10 first row pixel count", 64'(ncap), 64'd28);
        chk("R10 first row bg kept", 64'(cap_c[15]), 64'h222222);
        chk("R10 first row fg kept", 64'(cap_c[0]), 64'h111111);
        chk("R10 second row new fg", 64'(cap_c[16]), 64'h999999);
        chk("R10 second row y", 64'(cap_y[16]), 64'h0041);

        // R7 position write in the same cycle as a row acceptance
        cfg_write(3'd0, 64'h0100_0010);
        cfg_write(3'd1, 64'd4);
        cfg_write(3'd7, 64'h0);
        ncap = 0;
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 64'h0200_0020;
        row_valid = 1'b1; row_data = 32'hF000_0000;
        @(posedge clk); #1;
        cfg_we = 1'b0; row_valid = 1'b0;
        idle(10);
        send_row(32'hF000_0000, t1);
        idle(10);
        chk("R7 same-cycle row uses old x", 64'(cap_x[0]), 64'h0010);
        chk("R7 same-cycle row uses old y", 64'(cap_y[0]), 64'h0100);
        chk("R7 write beats advance x", 64'(cap_x[4]), 64'h0020);
        chk("R7 write beats advance y", 64'(cap_y[4]), 64'h0200);

        // R9 back-pressure: toggle px_ready during two rows
        cfg_write(3'd0, 64'h0003_0003);
        cfg_write(3'd2, 64'h0001_0000);
        cfg_write(3'd1, 64'd8);
        cfg_write(3'd3, 64'h0000AA);
        cfg_write(3'd4, 64'h005500);
        ncap = 0;
        n_hold = 0;
        fork
            begin
                repeat (40) begin
                    @(posedge clk); #1;
                    px_ready = ~px_ready;
                end
                px_ready = 1'b1;
            end
        join_none
        send_row(32'h3C00_0000, t1);
        send_row(32'hC300_0000, t2);
        idle(80);
        verify_rows("R9 stalled rows", 32'h0003_0003, 32'h0001_0000, 32'd8, 24'h0000AA,
                    24'h005500, 8'h83, 1'b0, 32'h3C00_0000, 32'hC300_0000);
        chk("R9 stalls observed", 64'(n_hold > 0), 64'd1);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule